// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block runs the write side of a small on-chip user flash array by itself, so the surrounding logic only has to load two serial registers and raise a request. A 9-bit address register and a 16-bit data register are filled serially, each through its own shift-clock input. A rising edge on the program request merges the data register into the selected word. A rising edge on the erase request wipes the whole sector that holds the selected word. A single busy flag stays high for the full fixed duration of either operation.

Reading goes through the same data register. A read strobe, honoured only while the block is idle, copies the addressed word into the data register in parallel. The word then leaves MSB first on the serial data output as the data shift clock is pulsed. The array is a behavioural model that starts fully erased. Reset does not touch it. The shift-clock inputs are oversampled by the system clock, so they must run well below it: at most 10 MHz against a 100 MHz system clock.

Top module: `flash_pe_seq`

## Requirements
- R1: A synchronous active-low reset clears the sequencer (busy low), the address register and the data register (serial output 0). It leaves the array contents unchanged, and it aborts an operation in progress without writing. The array starts with every word at 16'hFFFF.
- R2: The data register is 16 bits wide. On each sampled rising edge of data_sclk it shifts left by one and takes data_sin into bit 0. data_sout always shows bit 15, so a word goes in and comes out MSB first.
- R3: The address register is 9 bits wide and is shifted MSB first from addr_sin on rising edges of addr_sclk. Address bit 8 selects the sector: 0 covers words 0 to 255 and 1 covers words 256 to 511.
- R4: A program operation sets the addressed word to its old value ANDed with the data register, so programming can only clear bits.
- R5: An erase operation sets every word of the sector that holds the stored address to 16'hFFFF and leaves the other sector untouched.
- R6: busy goes high in the cycle after a request edge is sampled. It stays high for exactly 64 clock cycles for a program and 512 for an erase, and the result can be read once busy is low.
- R7: Only a 0-to-1 transition of prog_req or erase_req starts an operation. A request held high does not start another one.
- R8: Request edges that arrive while busy is high are ignored and do not lengthen the running operation.
- R9: When program and erase edges arrive in the same cycle, the erase is performed.
- R10: rd_stb loads the addressed word into the data register when busy is low. It has no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sclk | input | 1 | Address register shift clock |
| addr_sin | input | 1 | Address serial input, MSB first |
| data_sclk | input | 1 | Data register shift clock |
| data_sin | input | 1 | Data serial input, MSB first |
| data_sout | output | 1 | Data register MSB, serial output |
| prog_req | input | 1 | Program request, rising-edge active |
| erase_req | input | 1 | Sector erase request, rising-edge active |
| rd_stb | input | 1 | Parallel load of the addressed word into the data register |
| busy | output | 1 | Operation in progress |

## Verification
A request raised before a clock edge makes busy high one cycle later. The bench therefore drives at falling edges and starts counting busy at the next falling edge, which must give exactly 64 or 512 high samples. A shift-clock rise set at a falling edge is taken at the next rising edge, and data_sout moves right after it. A read strobe shows bit 15 at the falling edge that follows. For each readback the driver queues the value the requirements predict, and the monitor compares it with the 16 serially captured bits. Array contents are read back only after busy has been seen low again.

// File: rtl/flash_pe_pkg.sv
// Shared types for the flash program/erase sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package flash_pe_pkg;

    // Operation held by the sequencer.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } pe_op_t;

endpackage

// File: rtl/flash_pe_shreg.sv
// Serial-in shift register with an optional parallel load.
// The shift clock is oversampled by clk: a rising edge of sclk seen between
// two clk samples shifts sin into bit 0. Parallel load wins over a shift.
// Assumes sclk runs well below clk and sin is stable around its rising edge.
module flash_pe_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         sin,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);

    logic sclk_q;
    logic shift_edge;

    // Detect a rising edge of the oversampled shift clock.
    always_comb shift_edge = sclk && !sclk_q;

    // Register the shift clock and update the register contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            q      <= '0;
        end else begin
            sclk_q <= sclk;
            if (load_en) begin
                q <= load_val;
            end else if (shift_edge) begin
                q <= {q[W-2:0], sin};
            end
        end
    end

endmodule

// File: rtl/flash_pe_sequencer.sv
// Edge-triggered program/erase sequencer.
// A rising request edge while idle latches address and data and runs a fixed
// count. Erase wins a tie. The commit strobe fires in the last busy cycle.
// Assumes requests are synchronous to clk.
module flash_pe_sequencer
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 16,
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              commit_prog,
    output logic              commit_erase,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    pe_op_t             op;
    logic [CNT_W-1:0]   cnt;
    logic               prog_q;
    logic               erase_q;
    logic               prog_edge;
    logic               erase_edge;

    // Rising-edge detection of both requests.
    always_comb begin
        prog_edge  = prog_req && !prog_q;
        erase_edge = erase_req && !erase_q;
    end

    // Busy flag and commit strobes from the current operation and count.
    always_comb begin
        busy         = (op != OP_IDLE);
        commit_prog  = (op == OP_PROG)  && (cnt == '0);
        commit_erase = (op == OP_ERASE) && (cnt == '0);
    end

    // Operation start, countdown and return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op      <= OP_IDLE;
            cnt     <= '0;
            prog_q  <= 1'b0;
            erase_q <= 1'b0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            prog_q  <= prog_req;
            erase_q <= erase_req;
            if (op == OP_IDLE) begin
                if (erase_edge) begin
                    op      <= OP_ERASE;
                    cnt     <= CNT_W'(ERASE_CYC - 1);
                    op_addr <= addr_in;
                    op_data <= data_in;
                end else if (prog_edge) begin
                    op      <= OP_PROG;
                    cnt     <= CNT_W'(PROG_CYC - 1);
                    op_addr <= addr_in;
                    op_data <= data_in;
                end
            end else if (cnt == '0) begin
                op <= OP_IDLE;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_pe_array.sv
// Behavioural user flash array: word program by AND, sector erase to all ones.
// No reset: contents survive the block reset. Powers up erased.
// Assumes the top SECT_W address bits select the sector.
module flash_pe_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16,
    parameter int SECT_W = 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              er_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int SECT_SHIFT = ADDR_W - SECT_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Power-up state of the array is fully erased.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = '1;
        end
    end

    // Asynchronous read of the addressed word.
    always_comb rd_data = mem[rd_addr];

    // Program clears bits of one word; erase sets a whole sector.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
        if (er_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((ADDR_W'(i) >> SECT_SHIFT) == (wr_addr >> SECT_SHIFT)) begin
                    mem[i] <= '1;
                end
            end
        end
    end

endmodule

// File: rtl/flash_pe_seq.sv
// Flash program/erase sequencer top: serial address and data registers,
// edge-triggered sequencer and the behavioural array.
// Assumes shift clocks at most a tenth of clk and requests synchronous to clk.
module flash_pe_seq #(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 16,
    parameter int SECT_W    = 1,
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_sclk,
    input  logic addr_sin,
    input  logic data_sclk,
    input  logic data_sin,
    output logic data_sout,
    input  logic prog_req,
    input  logic erase_req,
    input  logic rd_stb,
    output logic busy
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic              commit_prog;
    logic              commit_erase;
    logic              load_en;

    // Parallel load is refused while an operation runs.
    always_comb load_en = rd_stb && !busy;

    // Serial output is the data register MSB.
    always_comb data_sout = data_q[DATA_W-1];

    flash_pe_shreg #(.W(ADDR_W)) u_addr_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (addr_sclk),
        .sin      (addr_sin),
        .load_en  (1'b0),
        .load_val ('0),
        .q        (addr_q)
    );

    flash_pe_shreg #(.W(DATA_W)) u_data_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (data_sclk),
        .sin      (data_sin),
        .load_en  (load_en),
        .load_val (rd_word),
        .q        (data_q)
    );

    flash_pe_sequencer #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_req     (prog_req),
        .erase_req    (erase_req),
        .addr_in      (addr_q),
        .data_in      (data_q),
        .busy         (busy),
        .commit_prog  (commit_prog),
        .commit_erase (commit_erase),
        .op_addr      (op_addr),
        .op_data      (op_data)
    );

    flash_pe_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SECT_W (SECT_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (commit_prog),
        .er_en   (commit_erase),
        .wr_addr (op_addr),
        .wr_data (op_data),
        .rd_addr (addr_q),
        .rd_data (rd_word)
    );

endmodule

// File: rtl/flash_pe_seq_chk.sv
// Assertion checker for flash_pe_seq, attached by bind.
// Keeps its own edge history and busy-length counter.
module flash_pe_seq_chk #(
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 512
) (
    input logic clk,
    input logic rst_n,
    input logic prog_req,
    input logic erase_req,
    input logic rd_stb,
    input logic data_sclk,
    input logic busy,
    input logic data_sout
);

    logic        prog_h;
    logic        erase_h;
    logic        dclk_h;
    logic        kind_erase;
    logic [15:0] bcnt;
    logic        p_rise;
    logic        e_rise;
    logic        d_rise;

    // Edges as seen by the checker's own history.
    always_comb begin
        p_rise = prog_req && !prog_h;
        e_rise = erase_req && !erase_h;
        d_rise = data_sclk && !dclk_h;
    end

    // Input history, operation kind and busy-length count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_h     <= 1'b0;
            erase_h    <= 1'b0;
            dclk_h     <= 1'b0;
            kind_erase <= 1'b0;
            bcnt       <= '0;
        end else begin
            prog_h  <= prog_req;
            erase_h <= erase_req;
            dclk_h  <= data_sclk;
            if (!busy && e_rise) begin
                kind_erase <= 1'b1;
            end else if (!busy && p_rise) begin
                kind_erase <= 1'b0;
            end
            bcnt <= busy ? bcnt + 16'd1 : 16'd0;
        end
    end

    // R7: busy rises only after a sampled request edge.
    p_start_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(p_rise || e_rise));

    // R7: with no edge, an idle sequencer stays idle.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !p_rise && !e_rise) |=> !busy);

    // R6: busy lasts exactly the count of the operation that was started.
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |->
            (bcnt == (kind_erase ? 16'(ERASE_CYC) : 16'(PROG_CYC))));

    // R8: busy cannot end early, whatever requests arrive.
    p_no_early_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (bcnt < 16'((kind_erase ? ERASE_CYC : PROG_CYC) - 1))) |=> busy);

    // R2: serial output moves only on a shift edge or a read strobe.
    p_sout_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_rise && !rd_stb) |=> $stable(data_sout));

endmodule

bind flash_pe_seq flash_pe_seq_chk #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_req  (prog_req),
    .erase_req (erase_req),
    .rd_stb    (rd_stb),
    .data_sclk (data_sclk),
    .busy      (busy),
    .data_sout (data_sout)
);

// File: tb/flash_pe_seq_tb.sv
// Scoreboard bench: driver tasks queue the expected readback words and a
// monitor process compares each serially captured word against the queue.
module flash_pe_seq_tb;

    localparam int PROG_N  = 64;
    localparam int ERASE_N = 512;
    localparam int WDOG    = 150000;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sclk = 1'b0;
    logic addr_sin = 1'b0;
    logic data_sclk = 1'b0;
    logic data_sin = 1'b0;
    logic data_sout;
    logic prog_req = 1'b0;
    logic erase_req = 1'b0;
    logic rd_stb = 1'b0;
    logic busy;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] model [512];
    exp_t        exp_q [$];
    logic [15:0] obs_word;
    event        obs_ev;

    always #5 clk = ~clk;

    flash_pe_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sclk (addr_sclk),
        .addr_sin  (addr_sin),
        .data_sclk (data_sclk),
        .data_sin  (data_sin),
        .data_sout (data_sout),
        .prog_req  (prog_req),
        .erase_req (erase_req),
        .rd_stb    (rd_stb),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Shift n bits of v, MSB first, into the address or data register.
    task automatic shift_in(input bit to_addr, input int n, input logic [15:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            if (to_addr) addr_sin = v[i]; else data_sin = v[i];
            repeat (4) @(negedge clk);
            if (to_addr) addr_sclk = 1'b1; else data_sclk = 1'b1;
            repeat (5) @(negedge clk);
            if (to_addr) addr_sclk = 1'b0; else data_sclk = 1'b0;
        end
    endtask

    // Capture 16 bits from data_sout, MSB first, and hand them to the monitor.
    task automatic unload(input logic [15:0] exp, input string tag);
        logic [15:0] w;
        exp_t e;
        e.val = exp;
        e.tag = tag;
        exp_q.push_back(e);
        data_sin = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            w[i] = data_sout;
            data_sclk = 1'b1;
            repeat (5) @(negedge clk);
            data_sclk = 1'b0;
            repeat (5) @(negedge clk);
        end
        obs_word = w;
        -> obs_ev;
        @(negedge clk);
    endtask

    // Load the addressed word with a read strobe and compare it with the model.
    task automatic read_word(input int a, input string tag);
        shift_in(1'b1, 9, 16'(a));
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        unload(model[a], tag);
    endtask

    // One-cycle request pulse; returns at the falling edge after the start edge.
    task automatic pulse(input bit p, input bit e);
        @(negedge clk);
        prog_req = p;
        erase_req = e;
        @(negedge clk);
        prog_req = 1'b0;
        erase_req = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic model_erase(input int a);
        for (int i = 0; i < 512; i++) begin
            if ((i >> 8) == (a >> 8)) model[i] = 16'hFFFF;
        end
    endtask

    // Monitor: pop the expected word and compare it with the captured word.
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "SB", "unexpected word", 32'(obs_word), 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(obs_word === e.val, e.tag, "readback", 32'(obs_word), 32'(e.val));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int  n;
        bit  saw;
        for (int i = 0; i < 512; i++) model[i] = 16'hFFFF;

        // R1: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
        check(data_sout === 1'b0, "R1", "sout after reset", 32'(data_sout), 0);
        read_word(40, "R1_erased_start");

        // R2, R4, R6: program into an erased word.
        shift_in(1'b1, 9, 16'd5);
        shift_in(1'b0, 16, 16'hA5C3);
        pulse(1'b1, 1'b0);
        count_busy(n);
        check(n == PROG_N, "R6", "program busy length", 32'(n), PROG_N);
        model[5] = model[5] & 16'hA5C3;
        read_word(5, "R4_R2_first_program");

        // R4: second program only clears bits.
        shift_in(1'b1, 9, 16'd5);
        shift_in(1'b0, 16, 16'h0FF0);
        pulse(1'b1, 1'b0);
        count_busy(n);
        model[5] = model[5] & 16'h0FF0;
        read_word(5, "R4_and_merge");

        // R3: word in the upper sector.
        shift_in(1'b1, 9, 16'd300);
        shift_in(1'b0, 16, 16'h1234);
        pulse(1'b1, 1'b0);
        count_busy(n);
        model[300] = model[300] & 16'h1234;
        read_word(300, "R3_upper_sector");

        // R5, R6: erase sector 0 through address 5.
        shift_in(1'b1, 9, 16'd5);
        pulse(1'b0, 1'b1);
        count_busy(n);
        check(n == ERASE_N, "R6", "erase busy length", 32'(n), ERASE_N);
        model_erase(5);
        read_word(5, "R5_sector_erased");
        read_word(300, "R5_other_sector_kept");

        // R7: held request runs once only.
        shift_in(1'b1, 9, 16'd9);
        shift_in(1'b0, 16, 16'h00FF);
        @(negedge clk);
        prog_req = 1'b1;
        @(negedge clk);
        count_busy(n);
        saw = 1'b0;
        repeat (100) begin
            @(negedge clk);
            if (busy) saw = 1'b1;
        end
        check(!saw, "R7", "held level retriggered", 32'(saw), 0);
        prog_req = 1'b0;
        model[9] = model[9] & 16'h00FF;
        read_word(9, "R7_single_program");

        // R8: erase edge during a program is ignored.
        shift_in(1'b1, 9, 16'd20);
        shift_in(1'b0, 16, 16'h0F0F);
        pulse(1'b1, 1'b0);
        n = 0;
        while (busy) begin
            n++;
            if (n == 10) erase_req = 1'b1;
            if (n == 11) erase_req = 1'b0;
            @(negedge clk);
        end
        check(n == PROG_N, "R8", "busy length with ignored edge", 32'(n), PROG_N);
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R8", "no late start", 32'(busy), 0);
        model[20] = model[20] & 16'h0F0F;
        read_word(9, "R8_no_erase");
        read_word(20, "R8_program_done");

        // R9: simultaneous edges perform an erase.
        shift_in(1'b1, 9, 16'd21);
        shift_in(1'b0, 16, 16'h0000);
        pulse(1'b1, 1'b1);
        count_busy(n);
        check(n == ERASE_N, "R9", "tie busy length", 32'(n), ERASE_N);
        model_erase(21);
        read_word(21, "R9_erase_not_program");
        read_word(20, "R9_sector_erased");

        // R10: read strobe during busy leaves the data register alone.
        shift_in(1'b1, 9, 16'd300);
        shift_in(1'b0, 16, 16'h1357);
        pulse(1'b0, 1'b1);
        repeat (20) @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        count_busy(n);
        model_erase(300);
        unload(16'h1357, "R10_strobe_ignored_busy");
        read_word(300, "R10_load_when_idle");

        // R1: reset in mid-program aborts without writing.
        shift_in(1'b1, 9, 16'd7);
        shift_in(1'b0, 16, 16'h8001);
        pulse(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(busy === 1'b0, "R1", "busy after mid-op reset", 32'(busy), 0);
        check(data_sout === 1'b0, "R1", "sout after mid-op reset", 32'(data_sout), 0);
        repeat (80) @(negedge clk);
        check(busy === 1'b0, "R1", "sequencer stays idle", 32'(busy), 0);
        read_word(7, "R1_aborted_no_write");
        read_word(300, "R1_array_kept");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "SB", "pending expected words", 32'(exp_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule